// File: doc/BRIEF.md
# Segmented Stack Word Engine

This block performs 16-bit stack push and pop transfers for a processor whose memory bus is one byte wide and whose addresses are formed from a segment and an offset. It owns the stack pointer. It receives the stack segment as an input and turns each word request into two byte cycles on a simple synchronous memory port that has a ready handshake.

A push accepts a word and moves the pointer down by two. It then writes the low byte and after it the high byte. A pop reads the low byte and then the high byte from the current pointer. It returns the assembled word and moves the pointer up by two. Every byte address is the segment shifted left by four plus an offset. The offset stays inside its 64 KB window, and the final sum wraps inside the 1 MB space.

Only one transfer runs at a time. The surrounding core watches `busy` and waits for the one-cycle `done` pulse. The core can also load the pointer directly while the engine is idle.

Top module: `stk_word_eng`

## Requirements
- R1: When `rst` is high at a clock edge, the pointer is cleared to 0x0000 and the engine becomes idle. After the edge, `busy`, `done`, `mem_wr` and `mem_rd` are all low.
- R2: If the engine is idle and neither `push_req` nor `pop_req` is high, `ptr_load` copies `ptr_load_val` into the pointer at the clock edge.
- R3: An accepted push lowers the pointer by two at the accepting edge. It then writes `push_word[7:0]` at the new pointer, and after that writes `push_word[15:8]` at the new pointer plus one. Exactly two write cycles occur, in that order.
- R4: An accepted pop reads the low byte at the pointer, then the high byte at the pointer plus one. It presents `{high, low}` on `pop_word` and raises the pointer by two when the second byte completes.
- R5: Every byte address equals (`stk_seg` × 16 + offset) mod 2^20. The segment used is the value sampled at the accepting edge; later changes to `stk_seg` during the transfer have no effect on it.
- R6: All offset arithmetic wraps modulo 2^16. This covers the pointer update and the plus-one offset of the high byte, for example 0xFFFF + 1 = 0x0000.
- R7: A byte cycle keeps `mem_addr`, `mem_wr`/`mem_rd` and `mem_wdata` unchanged until `mem_rdy` is high at a clock edge. Never more than one of the two strobes is high. With N wait cycles per byte, the cycle that holds `done` comes 2·(N+1) cycles after the first byte cycle starts.
- R8: `done` is high for exactly one cycle, the cycle after the second byte completes. `busy` is high from the accepting edge through the `done` cycle and is low after it.
- R9: While `busy` is high, `push_req`, `pop_req` and `ptr_load` are ignored. The pointer, the stored bytes and the number of byte cycles are exactly those of the transfer already running.
- R10: When `push_req` and `pop_req` are both high while the engine is idle, the push is taken and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stk_seg | input | 16 | Stack segment value |
| push_req | input | 1 | Start a push (idle only) |
| pop_req | input | 1 | Start a pop (idle only) |
| push_word | input | 16 | Word to push, sampled on acceptance |
| ptr_load | input | 1 | Load the pointer (idle, no request) |
| ptr_load_val | input | 16 | Value for a pointer load |
| mem_addr | output | 20 | Physical byte address |
| mem_wr | output | 1 | Byte write strobe |
| mem_rd | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, taken when `mem_rdy` is high |
| mem_rdy | input | 1 | Memory completes the current byte at this edge |
| pop_word | output | 16 | Word returned by the last pop |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A transfer is in progress |
| ptr | output | 16 | Current stack pointer |

## Verification
The bench builds the engine with its default widths: a 16-bit segment and offset, a four-bit segment shift and a 20-bit physical address. At these sizes both wrap points are reachable in a handful of transfers. Pointer values 0x0000 and 0x0001 cross the 64 KB offset boundary, on the pointer itself and on the high-byte offset. Segment 0xFFFF with small offsets pushes the sum past 2^20. The memory model inserts zero to four wait cycles per byte, so the hold behaviour, the `done` timing and the rejection of requests while busy are all exercised under stalls.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_FIN  = 2'd3
    } stk_state_e;

    typedef enum logic {
        OP_PUSH = 1'b0,
        OP_POP  = 1'b1
    } stk_op_e;

    function automatic logic in_byte_cycle(stk_state_e s);
        return (s == ST_LO) || (s == ST_HI);
    endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_req,
    input  logic       pop_req,
    input  logic       mem_rdy,
    output stk_state_e state,
    output stk_op_e    op,
    output logic       start_push,
    output logic       start_pop,
    output logic       lo_done,
    output logic       hi_done
);
    stk_state_e nxt;

    assign start_push = (state == ST_IDLE) && push_req;
    assign start_pop  = (state == ST_IDLE) && !push_req && pop_req;
    assign lo_done    = (state == ST_LO) && mem_rdy;
    assign hi_done    = (state == ST_HI) && mem_rdy;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start_push || start_pop) nxt = ST_LO;
            ST_LO:   if (mem_rdy) nxt = ST_HI;
            ST_HI:   if (mem_rdy) nxt = ST_FIN;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op    <= OP_PUSH;
        end else begin
            state <= nxt;
            if (start_push)     op <= OP_PUSH;
            else if (start_pop) op <= OP_POP;
        end
    end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OFS_W-1:0] load_val,
    input  logic             dec2,
    input  logic             inc2,
    output logic [OFS_W-1:0] sp
);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(2);

    always_ff @(posedge clk) begin
        if (rst)       sp <= '0;
        else if (dec2) sp <= sp - STEP;
        else if (inc2) sp <= sp + STEP;
        else if (load) sp <= load_val;
    end
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] sp,
    input  logic             hi_sel,
    output logic [PA_W-1:0]  addr
);
    localparam int BASE_W = SEG_W + SEG_SHIFT;

    logic [OFS_W-1:0]  ofs;
    logic [BASE_W-1:0] base_full;
    logic [PA_W-1:0]   base;

    assign ofs       = sp + OFS_W'(hi_sel);
    assign base_full = {seg, {SEG_SHIFT{1'b0}}};
    assign base      = PA_W'(base_full);
    assign addr      = base + PA_W'(ofs);
endmodule

// File: rtl/stk_word_eng.sv
module stk_word_eng
    import stk_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20,
    parameter int BYTE_W    = 8,
    localparam int WORD_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEG_W-1:0]  stk_seg,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              ptr_load,
    input  logic [OFS_W-1:0]  ptr_load_val,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic [WORD_W-1:0] pop_word,
    output logic              done,
    output logic              busy,
    output logic [OFS_W-1:0]  ptr
);
    stk_state_e        state;
    stk_op_e           op;
    logic              start_push, start_pop, lo_done, hi_done;
    logic              load_ok;
    logic [SEG_W-1:0]  seg_q;
    logic [WORD_W-1:0] wr_word_q;
    logic [BYTE_W-1:0] rd_lo_q;

    stk_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .push_req   (push_req),
        .pop_req    (pop_req),
        .mem_rdy    (mem_rdy),
        .state      (state),
        .op         (op),
        .start_push (start_push),
        .start_pop  (start_pop),
        .lo_done    (lo_done),
        .hi_done    (hi_done)
    );

    assign load_ok = (state == ST_IDLE) && !push_req && !pop_req && ptr_load;

    stk_ptr #(.OFS_W(OFS_W)) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (ptr_load_val),
        .dec2     (start_push),
        .inc2     (hi_done && (op == OP_POP)),
        .sp       (ptr)
    );

    stk_addr_gen #(
        .SEG_W     (SEG_W),
        .OFS_W     (OFS_W),
        .SEG_SHIFT (SEG_SHIFT),
        .PA_W      (PA_W)
    ) i_addr (
        .seg    (seg_q),
        .sp     (ptr),
        .hi_sel (state == ST_HI),
        .addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q     <= '0;
            wr_word_q <= '0;
            rd_lo_q   <= '0;
            pop_word  <= '0;
        end else begin
            if (start_push || start_pop) seg_q <= stk_seg;
            if (start_push) wr_word_q <= push_word;
            if (lo_done && (op == OP_POP)) rd_lo_q <= mem_rdata;
            if (hi_done && (op == OP_POP)) pop_word <= {mem_rdata, rd_lo_q};
        end
    end

    assign mem_wr    = in_byte_cycle(state) && (op == OP_PUSH);
    assign mem_rd    = in_byte_cycle(state) && (op == OP_POP);
    assign mem_wdata = (state == ST_HI) ? wr_word_q[BYTE_W +: BYTE_W]
                                        : wr_word_q[0 +: BYTE_W];
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);
endmodule

// File: rtl/stk_word_eng_chk.sv
module stk_word_eng_chk #(
    parameter int PA_W   = 20,
    parameter int BYTE_W = 8,
    parameter int OFS_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_rdy,
    input logic [PA_W-1:0]   mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic [OFS_W-1:0]  ptr
);
    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_wr, mem_rd}) <= 1);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_wr || mem_rd) && !mem_rdy) |=>
            ($stable(mem_addr) && $stable(mem_wr) && $stable(mem_rd) && $stable(mem_wdata)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr && !mem_rd && !done));

    // R9
    busy_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(mem_rd && mem_rdy)) |=> $stable(ptr));
endmodule

bind stk_word_eng stk_word_eng_chk i_chk (.*);

// File: tb/test_stk_word_eng.sv
module test_stk_word_eng;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] stk_seg = '0;
    logic        push_req = 1'b0, pop_req = 1'b0, ptr_load = 1'b0;
    logic [15:0] push_word = '0, ptr_load_val = '0;
    logic [19:0] mem_addr;
    logic        mem_wr, mem_rd, mem_rdy = 1'b0;
    logic [7:0]  mem_wdata, mem_rdata = '0;
    logic [15:0] pop_word, ptr;
    logic        done, busy;

    int total = 0;
    int bad = 0;

    stk_word_eng i_stk_word_eng (.*);

    always #4 clk = ~clk;

    // memory model with configurable wait cycles per byte
    logic [7:0] mem [int unsigned];
    int         wait_cfg = 0;
    int         wcnt = 0;
    logic [19:0] log_addr [0:7];
    logic        log_isw  [0:7];
    int          log_n = 0;

    always @(negedge clk) begin
        if (mem_wr || mem_rd) begin
            if (wcnt >= wait_cfg) begin mem_rdy <= 1'b1; wcnt <= 0; end
            else begin mem_rdy <= 1'b0; wcnt <= wcnt + 1; end
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        end else begin
            mem_rdy <= 1'b0;
            wcnt    <= 0;
        end
    end

    always @(posedge clk) begin
        if ((mem_wr || mem_rd) && mem_rdy) begin
            if (log_n < 8) begin
                log_addr[log_n] = mem_addr;
                log_isw[log_n]  = mem_wr;
            end
            log_n = log_n + 1;
            if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
        end
    end

    function automatic logic [19:0] pa(logic [15:0] s, logic [15:0] o);
        int unsigned v;
        v = (int'(s) * 16 + int'(o)) & 32'h000F_FFFF;
        return v[19:0];
    endfunction

    function automatic logic [7:0] rdmem(logic [19:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load_ptr(logic [15:0] v);
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = v;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    // requests high for one edge; segment input scrambled after acceptance
    task automatic start_op(bit do_push, bit do_pop, logic [15:0] w, logic [15:0] s);
        @(negedge clk);
        stk_seg = s; push_word = w; push_req = do_push; pop_req = do_pop; log_n = 0;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0; stk_seg = ~s;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // seg, sp, word, wait
    localparam logic [63:0] VEC [0:5] = '{
        {16'h2000, 16'h1234, 16'h1122, 16'd0},
        {16'h0000, 16'h0000, 16'hBEEF, 16'd1},
        {16'h0100, 16'h0001, 16'hA55A, 16'd2},
        {16'hFFFF, 16'h0020, 16'h1357, 16'd0},
        {16'hFFFF, 16'h0012, 16'h0F0F, 16'd3},
        {16'h1234, 16'h8000, 16'h80FE, 16'd1}
    };

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", 32'(ptr), 32'h0);
        chk("R1 busy/done", {30'd0, busy, done}, 32'h0);
        chk("R1 strobes", {30'd0, mem_wr, mem_rd}, 32'h0);

        foreach (VEC[i]) begin
            logic [15:0] s, p, w, pn;
            {s, p, w} = VEC[i][63:16];
            wait_cfg = int'(VEC[i][15:0]);
            pn = p - 16'd2;
            load_ptr(p);
            chk("R2 load", 32'(ptr), 32'(p));
            start_op(1'b1, 1'b0, w, s);
            wait_done(n);
            chk("R8 push done", 32'(done), 32'h1);
            chk("R3 push ptr", 32'(ptr), 32'(pn));
            chk("R3 push count", 32'(log_n), 32'd2);
            // R5 R6 addresses with segment relocation and offset wrap
            chk("R5 push lo addr", 32'(log_addr[0]), 32'(pa(s, pn)));
            chk("R6 push hi addr", 32'(log_addr[1]), 32'(pa(s, pn + 16'd1)));
            chk("R3 write flags", {30'd0, log_isw[0], log_isw[1]}, 32'h3);
            chk("R3 lo byte", 32'(rdmem(pa(s, pn))), 32'(w[7:0]));
            chk("R3 hi byte", 32'(rdmem(pa(s, pn + 16'd1))), 32'(w[15:8]));
            @(negedge clk);
            chk("R8 done cleared", {30'd0, done, busy}, 32'h0);
            start_op(1'b0, 1'b1, 16'h0000, s);
            wait_done(n);
            chk("R4 pop word", 32'(pop_word), 32'(w));
            chk("R4 pop ptr", 32'(ptr), 32'(p));
            chk("R4 pop lo addr", 32'(log_addr[0]), 32'(pa(s, pn)));
            chk("R4 pop hi addr", 32'(log_addr[1]), 32'(pa(s, pn + 16'd1)));
            chk("R4 read flags", {30'd0, log_isw[0], log_isw[1]}, 32'h0);
            @(negedge clk);
        end

        // R9 requests while busy are ignored
        wait_cfg = 3;
        load_ptr(16'h0400);
        start_op(1'b1, 1'b0, 16'hCAFE, 16'h0000);
        push_req = 1'b1; pop_req = 1'b1; ptr_load = 1'b1;
        ptr_load_val = 16'h7777; push_word = 16'h1111;
        repeat (2) @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0; ptr_load = 1'b0;
        wait_done(n);
        chk("R9 ptr", 32'(ptr), 32'h03FE);
        chk("R9 lo byte", 32'(rdmem(pa(16'h0000, 16'h03FE))), 32'hFE);
        chk("R9 hi byte", 32'(rdmem(pa(16'h0000, 16'h03FF))), 32'hCA);
        repeat (3) @(negedge clk);
        chk("R9 idle after", 32'(busy), 32'h0);
        chk("R9 no extra cycles", 32'(log_n), 32'd2);
        chk("R9 ptr kept", 32'(ptr), 32'h03FE);

        // R10 push wins over pop
        wait_cfg = 0;
        load_ptr(16'h0200);
        start_op(1'b1, 1'b1, 16'h4455, 16'h0030);
        wait_done(n);
        chk("R10 write taken", 32'(log_isw[0]), 32'h1);
        chk("R10 ptr", 32'(ptr), 32'h01FE);
        chk("R10 hi byte", 32'(rdmem(pa(16'h0030, 16'h01FF))), 32'h44);

        // R7 stall timing: 2*(wait+1) cycles to done
        wait_cfg = 4;
        start_op(1'b1, 1'b0, 16'h6789, 16'h0030);
        wait_done(n);
        chk("R7 stall cycles", 32'(n), 32'd10);
        chk("R8 busy with done", 32'(busy), 32'h1);
        @(negedge clk);
        chk("R8 single pulse", {30'd0, done, busy}, 32'h0);
        wait_cfg = 0;
        start_op(1'b1, 1'b0, 16'h0001, 16'h0030);
        wait_done(n);
        chk("R7 zero wait cycles", 32'(n), 32'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule